// File: doc/BRIEF.md
# Dual Multi-Mode Timer/Counter

The block holds two up-counting timer/counter channels. Each channel is a pair of 8-bit count registers, and a shared mode register and a shared control register configure both channels. A channel counts in one of two ways. In timer mode it counts a tick that fires once every twelve system clocks. In counter mode it counts falling edges on its own external count pin. A run bit enables counting, and an optional gate pin can also hold counting off.

When a count chain wraps, it sets an overflow flag, and each flag drives one interrupt request output. Four count shapes are available:
- a 13-bit chain with a 5-bit prescaled low part,
- a full 16-bit chain,
- an 8-bit counter that reloads itself from the high register,
- a split arrangement in which channel 0's two registers become two independent 8-bit counters.

A flat register port reads and writes all six registers. A per-channel acknowledge input clears the flags.

Top module: `tmr_dual`

## Requirements
- R1: Register addresses are: 0 channel-0 low, 1 channel-0 high, 2 channel-1 low, 3 channel-1 high, 4 mode, 5 control. All registers reset to 0. Reads are combinational. Addresses 6 and 7 read 0.
- R2: Mode 00 (13-bit). Only bits 4:0 of the low register count, and bits 7:5 keep their value. A carry out of bit 4 increments the high register. Wrapping from high FFh with low bits 1Fh sets the channel's flag.
- R3: Mode 01 (16-bit). {high, low} steps up by one per count. Going from FFFFh to 0000h sets the flag.
- R4: Mode 10 (reload). The low register counts. When it counts at FFh, it loads the high register's value instead and sets the flag.
- R5: When channel 0 uses mode 11 (split), four things apply. Channel-0 low counts with channel 0's enable and source, and sets flag 0. Channel-0 high counts timer ticks whenever run bit 1 is set, and sets flag 1. Channel 1 counts as 16-bit with its own enable and sets no flag. When channel 0 is not split, channel 1 in mode 11 holds its count.
- R6: Mode nibble bit 2 = 0 selects the timer tick, which occurs once every 12 clocks. Bit 2 = 1 selects counter mode. In counter mode, a 1-to-0 transition on the count pin, held low from a falling clock edge, increments the count on the third rising edge after it.
- R7: Counting requires the run bit. If nibble bit 3 (gate) is 1, it also requires the gate pin to be high.
- R8: A flag is cleared by writing 0 to it or by the acknowledge input. An overflow in the same cycle still sets it.
- R9: The mode register's low nibble configures channel 0 and its high nibble configures channel 1 (bits 1:0 select the mode). The control register holds flag 1 at bit 7, run 1 at bit 6, flag 0 at bit 5 and run 0 at bit 4. Bits 3:0 are plain storage.
- R10: A write to a count register in the same cycle as an increment of that register wins.
- R11: irq_o[n] equals flag n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i |
| t_pin_i | input | 2 | External count pins, one per channel |
| gate_pin_i | input | 2 | External gate pins, one per channel |
| irq_ack_i | input | 2 | Flag clear on acknowledge, one per channel |
| irq_o | output | 2 | Interrupt requests (overflow flags) |

## Verification
Register writes, increments and flag updates take effect at the next rising edge. Reads and irq_o show the new state at once, since both are combinational from the registers. A timer increment lands on every twelfth edge, and a count-pin fall reaches the count three edges after the pin drops.

The bench drives inputs at falling edges. Its behavioural model advances on each rising edge, and the bench compares irq_o and rdata_o two nanoseconds after each rising edge. Checks that depend on when the tick fires synchronise to the model's divider phase, and the pin-latency check samples the count at each of the three following edges.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    MODE_13     = 2'b00,
    MODE_16     = 2'b01,
    MODE_RELOAD = 2'b10,
    MODE_SPLIT  = 2'b11
  } tmr_mode_e;

  typedef struct packed {
    logic      gate;
    logic      ext;
    tmr_mode_e mode;
  } tmr_cfg_t;

  localparam int ADDR_MODE = 4;
  localparam int ADDR_CTRL = 5;
endpackage

// File: rtl/tmr_tick_div.sv
module tmr_tick_div #(
  parameter int DIV = 12
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int CW = $clog2(DIV);
  logic [CW-1:0] cnt_q;

  assign tick_o = (cnt_q == CW'(DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic fall_o
);
  logic [STAGES:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= {sr_q[STAGES-1:0], pin_i};
  end

  // older sample high, synchronized sample low
  assign fall_o = sr_q[STAGES] & ~sr_q[STAGES-1];
endmodule

// File: rtl/tmr_count_chain.sv
module tmr_count_chain
  import tmr_pkg::*;
#(
  parameter int W           = 8,
  parameter int LEGACY_BITS = 5
) (
  input  tmr_mode_e      mode_i,
  input  logic           inc_lo_i,
  input  logic           inc_hi_i,
  input  logic [W-1:0]   lo_i,
  input  logic [W-1:0]   hi_i,
  output logic [W-1:0]   lo_o,
  output logic [W-1:0]   hi_o,
  output logic           ovf_lo_o,
  output logic           ovf_hi_o
);
  always_comb begin
    lo_o     = lo_i;
    hi_o     = hi_i;
    ovf_lo_o = 1'b0;
    ovf_hi_o = 1'b0;
    unique case (mode_i)
      MODE_13: if (inc_lo_i) begin
        lo_o[LEGACY_BITS-1:0] = lo_i[LEGACY_BITS-1:0] + 1'b1;
        if (&lo_i[LEGACY_BITS-1:0]) begin
          hi_o     = hi_i + 1'b1;
          ovf_lo_o = &hi_i;
        end
      end
      MODE_16: if (inc_lo_i) begin
        {hi_o, lo_o} = {hi_i, lo_i} + 1'b1;
        ovf_lo_o     = &{hi_i, lo_i};
      end
      MODE_RELOAD: if (inc_lo_i) begin
        if (&lo_i) begin
          lo_o     = hi_i;
          ovf_lo_o = 1'b1;
        end else begin
          lo_o = lo_i + 1'b1;
        end
      end
      MODE_SPLIT: begin
        if (inc_lo_i) begin
          lo_o     = lo_i + 1'b1;
          ovf_lo_o = &lo_i;
        end
        if (inc_hi_i) begin
          hi_o     = hi_i + 1'b1;
          ovf_hi_o = &hi_i;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/tmr_dual.sv
module tmr_dual
  import tmr_pkg::*;
#(
  parameter int W           = 8,
  parameter int AW          = 3,
  parameter int DIV         = 12,
  parameter int SYNC_STAGES = 2,
  parameter int LEGACY_BITS = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [W-1:0]  wdata_i,
  output logic [W-1:0]  rdata_o,
  input  logic [1:0]    t_pin_i,
  input  logic [1:0]    gate_pin_i,
  input  logic [1:0]    irq_ack_i,
  output logic [1:0]    irq_o
);
  localparam int NREG   = 6;
  localparam int TR_BIT = W - 4;
  localparam int TF_BIT = W - 3;
  localparam int AUXW   = W - 4;

  logic [1:0][W-1:0] lo_q, hi_q, lo_nxt, hi_nxt;
  logic [W-1:0]      mode_q;
  logic [1:0]        tf_q, tr_q;
  logic [AUXW-1:0]   aux_q;

  logic              tick, split;
  tmr_cfg_t          cfg [2];
  tmr_mode_e         ch_mode [2];
  logic [1:0]        fall, run_en, inc, inc_lo, inc_hi, ovf_lo, ovf_hi, set_flag;
  logic [NREG-1:0]   wsel;

  tmr_tick_div #(.DIV(DIV)) u_div (.clk_i, .rst_ni, .tick_o(tick));

  for (genvar c = 0; c < 2; c++) begin : g_ch
    assign cfg[c] = tmr_cfg_t'(mode_q[4*c +: 4]);

    tmr_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i, .rst_ni, .pin_i(t_pin_i[c]), .fall_o(fall[c])
    );

    assign run_en[c] = tr_q[c] & (~cfg[c].gate | gate_pin_i[c]);
    assign inc[c]    = run_en[c] & (cfg[c].ext ? fall[c] : tick);

    tmr_count_chain #(.W(W), .LEGACY_BITS(LEGACY_BITS)) u_chain (
      .mode_i   (ch_mode[c]),
      .inc_lo_i (inc_lo[c]),
      .inc_hi_i (inc_hi[c]),
      .lo_i     (lo_q[c]),
      .hi_i     (hi_q[c]),
      .lo_o     (lo_nxt[c]),
      .hi_o     (hi_nxt[c]),
      .ovf_lo_o (ovf_lo[c]),
      .ovf_hi_o (ovf_hi[c])
    );
  end

  assign split = (cfg[0].mode == MODE_SPLIT);

  always_comb begin
    ch_mode[0] = cfg[0].mode;
    inc_lo[0]  = inc[0];
    inc_hi[0]  = tick & tr_q[1];          // split high half: timer tick, run bit 1
    ch_mode[1] = split ? MODE_16 : cfg[1].mode;
    inc_lo[1]  = inc[1] & (split | (cfg[1].mode != MODE_SPLIT));
    inc_hi[1]  = 1'b0;
    set_flag[0] = ovf_lo[0];
    set_flag[1] = split ? ovf_hi[0] : (ovf_lo[1] | ovf_hi[1]);
  end

  always_comb begin
    for (int i = 0; i < NREG; i++) wsel[i] = wr_en_i && (addr_i == AW'(i));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q   <= '0;
      hi_q   <= '0;
      mode_q <= '0;
      tf_q   <= '0;
      tr_q   <= '0;
      aux_q  <= '0;
    end else begin
      for (int c = 0; c < 2; c++) begin
        lo_q[c] <= wsel[2*c]   ? wdata_i : lo_nxt[c];
        hi_q[c] <= wsel[2*c+1] ? wdata_i : hi_nxt[c];
        // hardware set beats software write and acknowledge
        tf_q[c] <= set_flag[c] |
                   (wsel[ADDR_CTRL] ? wdata_i[TF_BIT+2*c] : (tf_q[c] & ~irq_ack_i[c]));
        if (wsel[ADDR_CTRL]) tr_q[c] <= wdata_i[TR_BIT+2*c];
      end
      if (wsel[ADDR_MODE]) mode_q <= wdata_i;
      if (wsel[ADDR_CTRL]) aux_q  <= wdata_i[AUXW-1:0];
    end
  end

  always_comb begin
    case (addr_i)
      AW'(0):         rdata_o = lo_q[0];
      AW'(1):         rdata_o = hi_q[0];
      AW'(2):         rdata_o = lo_q[1];
      AW'(3):         rdata_o = hi_q[1];
      AW'(ADDR_MODE): rdata_o = mode_q;
      AW'(ADDR_CTRL): rdata_o = {tf_q[1], tr_q[1], tf_q[0], tr_q[0], aux_q};
      default:        rdata_o = '0;
    endcase
  end

  assign irq_o = tf_q;
endmodule

// File: rtl/tmr_dual_chk.sv
module tmr_dual_chk #(
  parameter int W  = 8,
  parameter int AW = 3
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          wr_en_i,
  input logic [AW-1:0] addr_i,
  input logic [W-1:0]  rdata_o,
  input logic [1:0]    irq_o,
  input logic [1:0]    irq_ack_i,
  input logic [1:0]    set_flag,
  input logic          inc0,
  input logic          tr0,
  input logic [1:0]    mode0,
  input logic [W-1:0]  lo0,
  input logic [W-1:0]  hi0
);
  logic ctrl_wr;
  assign ctrl_wr = wr_en_i && (addr_i == AW'(5));

  AST_ACK_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_ack_i[0] && !set_flag[0] && !ctrl_wr) |=> !irq_o[0]); // R8

  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_flag[0] |=> irq_o[0]); // R8

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tr0 && !wr_en_i) |=> $stable(lo0)); // R7

  AST_WRAP_16: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode0 == 2'b01 && inc0 && &lo0 && &hi0 && !wr_en_i)
      |=> (irq_o[0] && lo0 == '0 && hi0 == '0)); // R3

  AST_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode0 == 2'b10 && inc0 && &lo0 && !wr_en_i) |=> (lo0 == $past(hi0))); // R4

  always_comb begin
    if (rst_ni && addr_i > AW'(5)) begin
      AST_ADDR_HOLE: assert (rdata_o == '0); // R1
    end
  end
endmodule

bind tmr_dual tmr_dual_chk #(.W(W), .AW(AW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .addr_i    (addr_i),
  .rdata_o   (rdata_o),
  .irq_o     (irq_o),
  .irq_ack_i (irq_ack_i),
  .set_flag  (set_flag),
  .inc0      (inc[0]),
  .tr0       (tr_q[0]),
  .mode0     (mode_q[1:0]),
  .lo0       (lo_q[0]),
  .hi0       (hi_q[0])
);

// File: tb/tmr_dual_bench.sv
module tmr_dual_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [1:0] t_pin = '0;
  logic [1:0] gate_pin = '0;
  logic [1:0] ack = '0;
  logic [1:0] irq;

  int nchk = 0;
  int nfail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  tmr_dual u_tmr_dual (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .t_pin_i(t_pin), .gate_pin_i(gate_pin), .irq_ack_i(ack), .irq_o(irq)
  );

  // behavioural reference
  int       mlo[2], mhi[2], mmode, maux, mdiv;
  bit       mtf[2], mtr[2];
  bit [2:0] msr[2];

  function automatic void adv(input int m, input bit il, input bit ih,
                              inout int lo, inout int hi, output bit ol, output bit oh);
    ol = 0; oh = 0;
    case (m)
      0: if (il) begin
        if (lo % 32 == 31) begin
          lo = lo - 31;
          if (hi == 255) begin hi = 0; ol = 1; end else hi++;
        end else lo++;
      end
      1: if (il) begin
        if (lo == 255) begin
          lo = 0;
          if (hi == 255) begin hi = 0; ol = 1; end else hi++;
        end else lo++;
      end
      2: if (il) begin
        if (lo == 255) begin lo = hi; ol = 1; end else lo++;
      end
      default: begin
        if (il) begin if (lo == 255) begin lo = 0; ol = 1; end else lo++; end
        if (ih) begin if (hi == 255) begin hi = 0; oh = 1; end else hi++; end
      end
    endcase
  endfunction

  function automatic int mread(input int a);
    case (a)
      0: return mlo[0];
      1: return mhi[0];
      2: return mlo[1];
      3: return mhi[1];
      4: return mmode;
      5: return (int'(mtf[1]) << 7) | (int'(mtr[1]) << 6) | (int'(mtf[0]) << 5) |
                (int'(mtr[0]) << 4) | maux;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    int l0, h0, l1, h1, nib, m1;
    bit tick, split, sp, o0l, o0h, o1l, o1h, s0, s1, wc;
    bit inc[2];
    if (!rst_n) begin
      mlo = '{0, 0}; mhi = '{0, 0}; mmode = 0; maux = 0; mdiv = 0;
      mtf = '{0, 0}; mtr = '{0, 0}; msr = '{3'b0, 3'b0};
    end else begin
      tick = (mdiv == 11);
      for (int c = 0; c < 2; c++) begin
        nib = (mmode >> (4 * c)) & 15;
        inc[c] = mtr[c] && (nib[3] == 0 || gate_pin[c]) &&
                 (nib[2] ? (msr[c][2] && !msr[c][1]) : tick);
      end
      split = (mmode & 3) == 3;
      l0 = mlo[0]; h0 = mhi[0]; l1 = mlo[1]; h1 = mhi[1];
      adv(mmode & 3, inc[0], tick && mtr[1], l0, h0, o0l, o0h);
      m1 = split ? 1 : ((mmode >> 4) & 3);
      adv(m1, inc[1] && m1 != 3, 1'b0, l1, h1, o1l, sp);
      s0 = o0l;
      s1 = split ? o0h : o1l;
      wc = wr_en && addr == 5;
      if (wr_en && addr == 0) l0 = wdata;
      if (wr_en && addr == 1) h0 = wdata;
      if (wr_en && addr == 2) l1 = wdata;
      if (wr_en && addr == 3) h1 = wdata;
      mtf[0] = s0 || (wc ? wdata[5] : (mtf[0] && !ack[0]));
      mtf[1] = s1 || (wc ? wdata[7] : (mtf[1] && !ack[1]));
      if (wc) begin mtr[0] = wdata[4]; mtr[1] = wdata[6]; maux = wdata & 15; end
      if (wr_en && addr == 4) mmode = wdata;
      mlo[0] = l0; mhi[0] = h0; mlo[1] = l1; mhi[1] = h1;
      mdiv = tick ? 0 : mdiv + 1;
      for (int c = 0; c < 2; c++) msr[c] = {msr[c][1:0], t_pin[c]};
    end
  end

  task automatic check(input int act, input int exp, input string tag);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #2;
    if (rst_n && !done) begin
      check(int'(irq), (int'(mtf[1]) << 1) | int'(mtf[0]), "R11 irq vs model");
      check(int'(rdata), mread(int'(addr)), "R1 rdata vs model");
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk); wr_en = 1; addr = 3'(a); wdata = 8'(d);
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd_chk(input int a, input int exp, input string tag);
    @(negedge clk); addr = 3'(a); #1;
    check(int'(rdata), exp, tag);
  endtask

  task automatic wait_irq(input int b, input string tag);
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (irq[b]) break;
    end
    check(int'(irq[b]), 1, tag);
  endtask

  task automatic pulse(input int c);
    @(negedge clk); t_pin[c] = 1;
    repeat (2) @(negedge clk);
    t_pin[c] = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic sync_tick();
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (mdiv == 11) break;
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("  %0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  endtask

  initial begin
    #(200000 * 8);
    nchk++; nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    for (int a = 0; a < 8; a++) rd_chk(a, 0, "R1 reset value");

    // R2 13-bit
    wr(4, 8'h00); wr(0, 8'hFF); wr(1, 8'hFF); wr(5, 8'h10);
    wait_irq(0, "R2 flag on 13-bit wrap");
    rd_chk(0, 8'hE0, "R2 low keeps bits 7:5");
    rd_chk(1, 8'h00, "R2 high wrapped");
    check(int'(irq), 1, "R11 irq pattern");
    @(negedge clk); ack = 2'b01; @(negedge clk); ack = 0; #1;
    check(int'(irq[0]), 0, "R8 ack clears flag");
    wr(5, 8'h00);

    // R3 16-bit
    wr(4, 8'h01); wr(0, 8'hFE); wr(1, 8'hFF); wr(5, 8'h10);
    wait_irq(0, "R3 flag on FFFF wrap");
    rd_chk(0, 0, "R3 low zero");
    rd_chk(1, 0, "R3 high zero");
    rd_chk(5, 8'h30, "R9 control layout");
    wr(5, 8'h10); #1;
    check(int'(irq[0]), 0, "R8 write zero clears flag");
    wr(5, 8'h00);

    // R4 reload
    wr(4, 8'h02); wr(1, 8'hFD); wr(0, 8'hFF); wr(5, 8'h10);
    wait_irq(0, "R4 flag on reload");
    rd_chk(0, 8'hFD, "R4 reloaded value");
    wr(5, 8'h00);

    // R6 counter source on channel 1
    wr(4, 8'h50); wr(2, 0); wr(3, 0); wr(5, 8'h40);
    for (int i = 0; i < 5; i++) pulse(1);
    rd_chk(2, 5, "R6 five pin falls counted");
    @(negedge clk); t_pin[1] = 1; repeat (3) @(negedge clk);
    t_pin[1] = 0;
    @(negedge clk); #1; check(int'(rdata), 5, "R6 no count after 1 edge");
    @(negedge clk); #1; check(int'(rdata), 5, "R6 no count after 2 edges");
    @(negedge clk); #1; check(int'(rdata), 6, "R6 count on 3rd edge");

    // R7 gate and run
    wr(4, 8'hD0);
    for (int i = 0; i < 3; i++) pulse(1);
    rd_chk(2, 6, "R7 gate low blocks");
    gate_pin[1] = 1;
    for (int i = 0; i < 2; i++) pulse(1);
    rd_chk(2, 8, "R7 gate high counts");
    wr(5, 8'h00);
    for (int i = 0; i < 2; i++) pulse(1);
    rd_chk(2, 8, "R7 run low blocks");
    gate_pin[1] = 0;

    // R5 split
    wr(4, 8'h03); wr(0, 8'hFE); wr(1, 8'hFE); wr(2, 8'hFF); wr(3, 8'hFF); wr(5, 8'h50);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk); addr = 0; #1;
      if (rdata == 8'hFF) break;
    end
    check(int'(irq), 0, "R5 channel 1 wrap sets no flag");
    rd_chk(2, 0, "R5 channel 1 low wrapped");
    rd_chk(3, 0, "R5 channel 1 high wrapped");
    wait_irq(0, "R5 split low flag");
    check(int'(irq), 3, "R5 split high sets flag 1");
    rd_chk(1, 0, "R5 split high wrapped");
    wr(5, 8'h00);
    @(negedge clk); ack = 2'b11; @(negedge clk); ack = 0;
    wr(4, 8'h30); wr(2, 8'h11); wr(5, 8'h40);
    repeat (30) @(negedge clk);
    rd_chk(2, 8'h11, "R5 channel 1 mode 11 holds");
    wr(5, 8'h00);

    // R10 write beats increment
    wr(4, 8'h01); wr(0, 0); wr(1, 0); wr(5, 8'h10);
    sync_tick();
    wr_en = 1; addr = 0; wdata = 8'h55;
    @(negedge clk); wr_en = 0;
    rd_chk(0, 8'h55, "R10 write wins over increment");

    // R8 set beats software clear
    wr(5, 8'h00); wr(1, 8'hFF); wr(0, 8'hFF);
    sync_tick();
    wr_en = 1; addr = 5; wdata = 8'h10;
    @(negedge clk); wr_en = 0;
    sync_tick();
    wr_en = 1; addr = 5; wdata = 8'h10;
    @(negedge clk); wr_en = 0; #1;
    check(int'(irq[0]), 1, "R8 overflow beats write clear");

    // R9 storage bits, mode readback, R1 holes
    wr(5, 8'h0A);
    rd_chk(5, 8'h0A, "R9 control low bits stored");
    check(int'(irq), 0, "R8 flag cleared by write");
    wr(4, 8'hA5);
    rd_chk(4, 8'hA5, "R9 mode readback");
    rd_chk(6, 0, "R1 hole 6");
    rd_chk(7, 0, "R1 hole 7");

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule